// File: doc/BRIEF.md
# Passive Serial Bitstream Loader

This block is the host side of a five-wire passive serial configuration link. On a start pulse it pulls the target's active-low configuration request low and keeps the serial clock low. It waits for the target to acknowledge by pulling its active-low status line low. It then streams a bitstream of known length out of a byte-wide memory, one bit per serial clock pulse. After each falling edge of the serial clock it checks the status line. After the last bit it checks the configuration-done input.

Any failed attempt causes a short release of the request line and a full restart, up to a parameter number of restarts. When the restarts run out, the block stops with a sticky error flag. After a good load it sends a parameter number of extra clock pulses so the target can finish initializing, and then it raises done. All timing counts come from the system clock, using a cycles-per-microsecond parameter.

Top module: `ps_cfg_master`

## Requirements
- R1: After reset, cfg_req_n is 1, ser_clk is 0, ser_dat is 0, and busy, done and error are all 0.
- R2: A start pulse in the idle or done state drives cfg_req_n low with ser_clk low. The hold period lasts HOLD_US*CYC_PER_US cycles. ser_clk never goes high while cfg_req_n is low.
- R3: tgt_stat_n is sampled in the last cycle of the hold period. If it reads 1 there (no acknowledge), the attempt fails, so cfg_req_n is low for exactly the hold length in that attempt.
- R4: After an acknowledge, cfg_req_n stays low for a further WAIT_US*CYC_PER_US cycles and is then released to 1. An accepted attempt keeps cfg_req_n low for exactly (HOLD_US+WAIT_US)*CYC_PER_US cycles.
- R5: Byte k of the bitstream is read at address START_ADDR+k (k = 0..LEN_BYTES-1) through a read port with no latency. Bytes go out in increasing address order and each byte goes out LSB first. ser_dat is set HALF_CYC cycles before each rising edge, ser_clk stays high for HALF_CYC cycles, and ser_dat is stable while ser_clk is high.
- R6: tgt_stat_n is sampled in the cycle after each data falling edge. A 0 there fails the attempt.
- R7: After the last data bit, tgt_cfg_done must read 1 in that same check cycle, otherwise the attempt fails.
- R8: A failed attempt holds cfg_req_n high with ser_clk low for CYC_PER_US cycles and then starts a new hold period. At most MAX_RETRY such restarts follow one start pulse.
- R9: A failure with no restarts left raises error. error stays high until reset, with busy 0 and cfg_req_n 1, and start pulses are ignored.
- R10: After a good load, exactly TRAIL_CLKS further ser_clk pulses are sent, and then done rises and busy falls.
- R11: A start pulse while busy has no effect. A start pulse while done begins a new load.
- R12: done and error are never high together, and busy is 0 whenever done or error is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a load |
| cfg_req_n | output | 1 | Active-low configuration request to the target |
| tgt_stat_n | input | 1 | Active-low status from the target |
| tgt_cfg_done | input | 1 | Configuration-done from the target |
| ser_clk | output | 1 | Serial clock to the target |
| ser_dat | output | 1 | Serial data to the target |
| mem_addr | output | AW | Bitstream memory byte address |
| mem_rdata | input | 8 | Bitstream memory byte, valid in the same cycle as mem_addr |
| busy | output | 1 | A load is in progress |
| done | output | 1 | Last load finished successfully |
| error | output | 1 | Sticky: retries exhausted |

## Verification
The bench builds the loader with 4 cycles per microsecond, a 2-cycle half period, a 6-byte bitstream at address 16, 10 trailing clocks and 2 restarts. With these values every hold, wait, release gap and pulse width is a short exact count that can be measured, and a full load takes a few hundred cycles. Because the restart limit is small, retry exhaustion is reached with a target that never acknowledges. A bench target model injects a status fault at a random bit, or withholds configuration-done once, across random bitstreams and random acknowledge delays.

// File: rtl/ps_cfg_master.sv
module ps_cfg_master #(
  parameter int CYC_PER_US = 50,
  parameter int HOLD_US    = 3,
  parameter int WAIT_US    = 5,
  parameter int HALF_CYC   = 8,
  parameter int AW         = 16,
  parameter int START_ADDR = 0,
  parameter int LEN_BYTES  = 1024,
  parameter int TRAIL_CLKS = 16,
  parameter int MAX_RETRY  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          cfg_req_n,
  input  logic          tgt_stat_n,
  input  logic          tgt_cfg_done,
  output logic          ser_clk,
  output logic          ser_dat,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_rdata,
  output logic          busy,
  output logic          done,
  output logic          error
);
  localparam int HOLD_CYC = HOLD_US * CYC_PER_US;
  localparam int WAIT_CYC = WAIT_US * CYC_PER_US;
  localparam int MAX_A    = (HOLD_CYC > WAIT_CYC) ? HOLD_CYC : WAIT_CYC;
  localparam int MAX_B    = (CYC_PER_US > HALF_CYC) ? CYC_PER_US : HALF_CYC;
  localparam int MAXC     = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW       = $clog2(MAXC + 1);
  localparam int YW       = (LEN_BYTES > 1) ? $clog2(LEN_BYTES) : 1;
  localparam int TW       = $clog2(TRAIL_CLKS + 1);
  localparam int RW       = $clog2(MAX_RETRY + 1);

  localparam logic [CW-1:0] HOLD_END = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] WAIT_END = CW'(WAIT_CYC - 1);
  localparam logic [CW-1:0] HALF_END = CW'(HALF_CYC - 1);
  localparam logic [CW-1:0] GAP_END  = CW'(CYC_PER_US - 1);
  localparam logic [YW-1:0] LAST_BYTE = YW'(LEN_BYTES - 1);
  localparam logic [TW-1:0] LAST_TRL  = TW'(TRAIL_CLKS - 1);
  localparam logic [RW-1:0] RETRY_LIM = RW'(MAX_RETRY);

  typedef enum logic [3:0] {
    S_IDLE, S_HOLD, S_WAIT, S_BLO, S_BHI, S_CHK, S_GAP, S_TLO, S_THI, S_DONE, S_ERR
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [YW-1:0] byte_i;
  logic [2:0]    bit_i;
  logic [TW-1:0] tcnt;
  logic [RW-1:0] rcnt;
  logic          last_bit, bad;

  assign last_bit = (byte_i == LAST_BYTE) && (bit_i == 3'd7);
  assign bad = (st == S_HOLD && cnt == HOLD_END && tgt_stat_n) ||
               (st == S_CHK && (!tgt_stat_n || (last_bit && !tgt_cfg_done)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; byte_i <= '0; bit_i <= '0; tcnt <= '0; rcnt <= '0;
    end else if (bad) begin
      cnt <= '0;
      if (rcnt == RETRY_LIM) st <= S_ERR;
      else begin
        rcnt <= rcnt + 1'b1;
        st   <= S_GAP;
      end
    end else begin
      case (st)
        S_IDLE, S_DONE: if (start) begin st <= S_HOLD; cnt <= '0; rcnt <= '0; end
        S_HOLD: if (cnt == HOLD_END) begin st <= S_WAIT; cnt <= '0; end
                else cnt <= cnt + 1'b1;
        S_WAIT: if (cnt == WAIT_END) begin
                  st <= S_BLO; cnt <= '0; byte_i <= '0; bit_i <= '0;
                end else cnt <= cnt + 1'b1;
        S_BLO:  if (cnt == HALF_END) begin st <= S_BHI; cnt <= '0; end
                else cnt <= cnt + 1'b1;
        S_BHI:  if (cnt == HALF_END) begin st <= S_CHK; cnt <= '0; end
                else cnt <= cnt + 1'b1;
        S_CHK:  if (last_bit) begin st <= S_TLO; tcnt <= '0; end
                else begin
                  st    <= S_BLO;
                  bit_i <= bit_i + 3'd1;
                  if (bit_i == 3'd7) byte_i <= byte_i + 1'b1;
                end
        S_GAP:  if (cnt == GAP_END) begin st <= S_HOLD; cnt <= '0; end
                else cnt <= cnt + 1'b1;
        S_TLO:  if (cnt == HALF_END) begin st <= S_THI; cnt <= '0; end
                else cnt <= cnt + 1'b1;
        S_THI:  if (cnt == HALF_END) begin
                  cnt <= '0;
                  if (tcnt == LAST_TRL) st <= S_DONE;
                  else begin tcnt <= tcnt + 1'b1; st <= S_TLO; end
                end else cnt <= cnt + 1'b1;
        default: st <= st;
      endcase
    end
  end

  assign cfg_req_n = !(st == S_HOLD || st == S_WAIT);
  assign ser_clk   = (st == S_BHI) || (st == S_THI);
  assign ser_dat   = (st == S_BLO || st == S_BHI || st == S_CHK) && mem_rdata[bit_i];
  assign mem_addr  = AW'(START_ADDR) + AW'(byte_i);
  assign done      = (st == S_DONE);
  assign error     = (st == S_ERR);
  assign busy      = !(st == S_IDLE || st == S_DONE || st == S_ERR);
endmodule

module ps_cfg_master_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic cfg_req_n,
  input logic ser_clk,
  input logic ser_dat,
  input logic busy,
  input logic done,
  input logic error
);
  // R2
  clk_low_in_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_req_n |-> !ser_clk);
  // R5
  dat_stable_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |=> (!ser_clk || $stable(ser_dat)));
  // R9
  error_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> (error && cfg_req_n && !busy));
  // R11
  done_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> (busy && !cfg_req_n));
  // R12
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error) && !((done || error) && busy));
endmodule

bind ps_cfg_master ps_cfg_master_chk i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cfg_req_n(cfg_req_n),
  .ser_clk(ser_clk), .ser_dat(ser_dat), .busy(busy), .done(done), .error(error)
);

// File: tb/test_ps_cfg_master.sv
module test_ps_cfg_master;
  localparam int CPU = 4, HOLD_US = 3, WAIT_US = 5, HALF = 2, AW = 8;
  localparam int START = 16, LEN = 6, TRAIL = 10, MAXR = 2;
  localparam int NB = LEN * 8;

  logic clk = 0, rst_n = 0, start = 0;
  logic cfg_req_n, ser_clk, ser_dat, busy, done, error;
  logic tgt_stat_n, tgt_cfg_done;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem [256];
  logic [7:0] mem_rdata;

  always #4 clk = ~clk;
  assign mem_rdata = mem[mem_addr];

  ps_cfg_master #(.CYC_PER_US(CPU), .HOLD_US(HOLD_US), .WAIT_US(WAIT_US), .HALF_CYC(HALF),
    .AW(AW), .START_ADDR(START), .LEN_BYTES(LEN), .TRAIL_CLKS(TRAIL), .MAX_RETRY(MAXR))
  i_ps_cfg_master (.clk(clk), .rst_n(rst_n), .start(start), .cfg_req_n(cfg_req_n),
    .tgt_stat_n(tgt_stat_n), .tgt_cfg_done(tgt_cfg_done), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .busy(busy), .done(done), .error(error));

  int errors = 0, checks = 0;
  bit finished = 0;
  // target model knobs (written by the stimulus only)
  bit no_ack = 0;
  int ack_delay = 1, fault_att = -1, fault_bit = 0, cbad_att = -1;
  // target model / monitor state (written by the monitor only)
  int attempts, low_cnt, last_low, hi_run, last_gap, bitcnt, rises, mism;
  int low_clk_viol, hi_viol, width_viol, hi_len;
  logic prev_req, prev_clk, prev_dat;

  function automatic logic exp_bit(int i);
    return mem[START + i / 8][i % 8];
  endfunction

  function automatic int exp_attempts(bit na, int fb, bit cb);
    if (na) return MAXR + 1;
    return 1 + ((fb >= 0 || cb) ? 1 : 0);
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      attempts = 0; low_cnt = 0; last_low = 0; hi_run = 0; last_gap = 0; bitcnt = 0;
      rises = 0; mism = 0; low_clk_viol = 0; hi_viol = 0; width_viol = 0; hi_len = 0;
      prev_req = 1; prev_clk = 0; prev_dat = 0; tgt_stat_n = 1; tgt_cfg_done = 0;
    end else begin
      if (!cfg_req_n && prev_req) begin
        attempts++; last_gap = hi_run; low_cnt = 0; bitcnt = 0; rises = 0; mism = 0;
        tgt_cfg_done = 0;
      end
      if (cfg_req_n && !prev_req) begin last_low = low_cnt; tgt_stat_n = 1; end
      if (!cfg_req_n) begin
        low_cnt++; hi_run = 0;
        if (ser_clk) low_clk_viol++;
        tgt_stat_n = (no_ack || low_cnt < ack_delay);
      end else hi_run++;
      if (ser_clk && !prev_clk && cfg_req_n) begin
        if (bitcnt < NB) begin
          if (ser_dat !== exp_bit(bitcnt)) mism++;
          if (attempts == fault_att && bitcnt == fault_bit) tgt_stat_n = 0;
        end
        bitcnt++; rises++;
        if (bitcnt == NB && attempts != cbad_att) tgt_cfg_done = (mism == 0);
      end
      if (ser_clk && prev_clk && ser_dat !== prev_dat) hi_viol++;
      if (ser_clk) hi_len++;
      else if (prev_clk) begin
        if (hi_len != HALF) width_viol++;
        hi_len = 0;
      end
      prev_req = cfg_req_n; prev_clk = ser_clk; prev_dat = ser_dat;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 20000 && !(done || error); i++) @(negedge clk);
  endtask

  task automatic run(input bit na, input int fb, input bit cb, input bit poke_busy);
    int a0, ea;
    a0 = attempts;
    for (int i = 0; i < LEN; i++) mem[START + i] = 8'($urandom);
    no_ack = na;
    ack_delay = 1 + int'($urandom % CPU);
    fault_att = (fb >= 0) ? a0 + 1 : -1;
    fault_bit = fb;
    cbad_att = cb ? a0 + 1 : -1;
    pulse_start();
    if (poke_busy) begin
      repeat (60) @(negedge clk);
      pulse_start();
    end
    wait_end();
    @(negedge clk);
    ea = exp_attempts(na, fb, cb);
    chk(attempts - a0 == ea, na ? "R3 attempts without ack" :
        (fb >= 0) ? "R6 attempts after status fault" :
        cb ? "R7 attempts after missing done" : "R11 attempts single run", attempts - a0, ea);
    if (!na) begin
      chk(done && !error && !busy, "R12 done flags", {done, error, busy}, 3'b100);
      chk(mism == 0, "R5 serial data LSB first", mism, 0);
      chk(last_low == (HOLD_US + WAIT_US) * CPU, "R4 request low length", last_low,
          (HOLD_US + WAIT_US) * CPU);
      chk(rises == NB + TRAIL, "R10 clock pulses incl trailing", rises, NB + TRAIL);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(cfg_req_n && !ser_clk && !ser_dat && !busy && !done && !error, "R1 reset state",
        {cfg_req_n, ser_clk, ser_dat, busy, done, error}, 6'b100000);
    rst_n = 1;
    repeat (2) @(negedge clk);

    run(0, -1, 0, 1);
    run(0, 0, 0, 0);
    run(0, NB - 1, 0, 0);
    run(0, -1, 1, 0);
    for (int k = 0; k < 6; k++) begin
      int pick;
      pick = int'($urandom % 3);
      run(0, (pick == 1) ? int'($urandom % NB) : -1, pick == 2, 0);
    end
    chk(low_clk_viol == 0, "R2 clock low during request", low_clk_viol, 0);
    chk(hi_viol == 0, "R5 data stable while clock high", hi_viol, 0);
    chk(width_viol == 0, "R5 clock high width", width_viol, 0);

    run(1, -1, 0, 0);
    chk(error && !done && !busy && cfg_req_n, "R9 error state",
        {error, done, busy, cfg_req_n}, 4'b1001);
    chk(last_low == HOLD_US * CPU, "R3 hold-only attempt length", last_low, HOLD_US * CPU);
    chk(last_gap == CPU, "R8 release gap", last_gap, CPU);
    begin
      int a0;
      a0 = attempts;
      pulse_start();
      repeat (40) @(negedge clk);
      chk(attempts == a0 && error && cfg_req_n, "R9 start ignored after error", attempts, a0);
    end

    rst_n = 0;
    repeat (2) @(negedge clk);
    chk(cfg_req_n && !ser_clk && !busy && !done && !error, "R1 state after second reset",
        {cfg_req_n, ser_clk, busy, done, error}, 5'b10000);
    rst_n = 1;
    no_ack = 0;
    @(negedge clk);
    run(0, -1, 0, 0);
    run(0, int'($urandom % NB), 0, 0);

    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule